// File: doc/BRIEF.md
# Half-Duplex Transmit Access Arbiter

This block decides when a half-duplex Ethernet MAC may put a frame on a shared medium. A frame source raises a request and holds it. The arbiter then waits for the carrier to go quiet before it grants the transmitter. If a collision is seen while the grant is up, it withdraws the grant and asks for a jam pattern. After the jam it either gives up on the frame or waits a random backoff and competes again. When the frame ends, whether it succeeded or was dropped, the block issues a one-cycle status word that names the outcome and the number of collisions.

All timing is counted in bit times, using a `bit_tick` strobe supplied by the media clock domain logic. Three configuration inputs choose the abort policy:
- a deferral watchdog that drops frames which wait too long;
- a switch that turns off retries altogether;
- a switch that lets late collisions be retried like early ones.

The request and the status behave as a simple stream pair. `tx_req` acts as the valid signal of a frame and is held until `status_valid` is seen. The frame source drops `tx_req` in the cycle it observes `status_valid`. `status_valid` is a single-cycle pulse with no back-pressure, so the consumer must take the status word in that cycle.

Top module: `hdx_tx_arbiter`

## Requirements
- R1: `tx_en` rises only after a clock edge at which `crs` was low. While `crs` stays high the block keeps waiting and `tx_en` stays low.
- R2: When `cfg_defer_chk` is 1 and the carrier has been busy for more than DEFER_LIMIT ticks of one frame's wait, the frame is dropped with status bit 1 set and a collision count of 0. When `cfg_defer_chk` is 0 the block waits for as long as the carrier is busy.
- R3: When `col` is high during a grant, `tx_en` falls on the next edge and `jam` is asserted for exactly JAM_BITS ticks.
- R4: When `cfg_retry_dis` is 1, the first collision drops the frame after its jam, with status bit 4 set.
- R5: A collision is late when at least LATE_BITS ticks of the grant have passed before it. A late collision with `cfg_late_retry` at 0 drops the frame with status bit 3 set. With `cfg_late_retry` at 1, a late collision is retried like an early one.
- R6: When the collision count reaches MAX_ATTEMPTS, the frame is dropped with status bit 2 set.
- R7: Any other collision is followed by a backoff phase. `backoff_active` stays high for k*SLOT_BITS+1 clock cycles (at one tick per cycle), where k lies in [0, 2^min(n,BACKOFF_CAP)-1] and n is the collision count. During backoff, `tx_en` and `jam` stay low. The block then defers again.
- R8: When `frame_end` is high during a grant and no collision occurs in that cycle, the frame succeeds with status bit 0 set.
- R9: Every status word has exactly one of bits 4:0 set, and bits 9:5 hold the number of collisions (for MAX_ATTEMPTS = 16). `status_valid` is high for exactly one cycle per frame.
- R10: After a collision the drop checks are made in a fixed order: retry disable first, then late collision, then the collision limit.
- R11: During reset and right after it, `tx_en`, `jam`, `backoff_active` and `status_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Frame ready; held until status_valid |
| crs | input | 1 | Carrier sense from the medium |
| col | input | 1 | Collision indication from the medium |
| bit_tick | input | 1 | One pulse per bit time |
| frame_end | input | 1 | Last bit of the frame sent |
| cfg_defer_chk | input | 1 | Enable excessive-deferral drop |
| cfg_retry_dis | input | 1 | Drop on first collision |
| cfg_late_retry | input | 1 | Retry late collisions instead of dropping |
| tx_en | output | 1 | Transmit grant |
| jam | output | 1 | Send jam pattern |
| backoff_active | output | 1 | Backoff wait in progress |
| status_valid | output | 1 | One-cycle status strobe |
| status | output | 5+$clog2(MAX_ATTEMPTS+1) | Outcome bits 4:0, collision count above |

## Verification
The in-RTL assertions check the following on every cycle:
- the grant only rises after a quiet carrier edge;
- a collision during a grant is always followed by a jam;
- the grant and the jam stay silent during backoff;
- each status word is one-hot in its outcome field;
- the collision and deferral counters stay within their limits;
- every loaded backoff stays inside the window for the current attempt.

Other behaviour can only be shown by the bench's frame scenarios, because it depends on a whole frame's history:
- that the right outcome is chosen, including the order of the drop checks when several apply;
- the exact jam length and the slot-multiple backoff lengths;
- the deferral watchdog on both sides of its limit;
- the retry of late collisions when that switch is set.

// File: rtl/hdx_tx_pkg.sv
package hdx_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEFER, ST_XMIT, ST_JAM, ST_BACKOFF, ST_DONE
  } arb_state_t;

  localparam int OUTCOME_W = 5;
  localparam logic [OUTCOME_W-1:0] OUT_OK        = 5'b00001;
  localparam logic [OUTCOME_W-1:0] OUT_DEFER     = 5'b00010;
  localparam logic [OUTCOME_W-1:0] OUT_EXCESS    = 5'b00100;
  localparam logic [OUTCOME_W-1:0] OUT_LATE      = 5'b01000;
  localparam logic [OUTCOME_W-1:0] OUT_RETRY_OFF = 5'b10000;
endpackage

// File: rtl/hdx_defer_timer.sv
module hdx_defer_timer #(
  parameter int LIMIT = 24288,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic expired
);
  logic [CW-1:0] busy_ticks;

  assign expired = count_en && (busy_ticks == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) busy_ticks <= '0;
    else if (count_en && !expired) busy_ticks <= busy_ticks + 1'b1;
  end

  AST_DEFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_ticks <= CW'(LIMIT)); // R2
endmodule

// File: rtl/hdx_backoff.sv
module hdx_backoff #(
  parameter int SLOT_BITS   = 512,
  parameter int BACKOFF_CAP = 10,
  parameter int ATT_W       = 5,
  localparam int SW = BACKOFF_CAP,
  localparam int RW = BACKOFF_CAP + $clog2(SLOT_BITS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ATT_W-1:0] attempt,
  input  logic             tick,
  output logic             busy
);
  logic [15:0]   lfsr;
  logic [RW-1:0] remaining;
  logic [SW-1:0] mask;
  logic [SW-1:0] slots;
  logic [RW-1:0] win_max;
  int            expo;

  always_comb begin
    expo = (int'(attempt) < BACKOFF_CAP) ? int'(attempt) : BACKOFF_CAP;
    mask = SW'((64'd1 << expo) - 64'd1);
    slots = SW'(lfsr) & mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) remaining <= '0;
    else if (start) remaining <= RW'(slots) * RW'(SLOT_BITS);
    else if (tick && remaining != '0) remaining <= remaining - 1'b1;
  end

  assign busy = (remaining != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) win_max <= '0;
    else if (start) win_max <= RW'(mask) * RW'(SLOT_BITS);
  end

  AST_BACKOFF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> remaining <= win_max); // R7
endmodule

// File: rtl/hdx_tx_arbiter.sv
module hdx_tx_arbiter
  import hdx_tx_pkg::*;
#(
  parameter int DEFER_LIMIT  = 24288,
  parameter int SLOT_BITS    = 512,
  parameter int JAM_BITS     = 32,
  parameter int LATE_BITS    = 512,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10,
  localparam int CNT_W  = $clog2(MAX_ATTEMPTS + 1),
  localparam int STAT_W = OUTCOME_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic              crs,
  input  logic              col,
  input  logic              bit_tick,
  input  logic              frame_end,
  input  logic              cfg_defer_chk,
  input  logic              cfg_retry_dis,
  input  logic              cfg_late_retry,
  output logic              tx_en,
  output logic              jam,
  output logic              backoff_active,
  output logic              status_valid,
  output logic [STAT_W-1:0] status
);
  localparam int BW = $clog2(LATE_BITS + 1);
  localparam int JW = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;

  arb_state_t     state;
  logic [CNT_W-1:0] coll_cnt;
  logic           late_hit;
  logic [BW-1:0]  bit_cnt;
  logic [JW-1:0]  jam_cnt;
  logic           defer_exp;
  logic           bo_busy;
  logic           jam_last;
  logic           drop_now;
  logic [OUTCOME_W-1:0] drop_code;

  hdx_defer_timer #(.LIMIT(DEFER_LIMIT)) u_defer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (state == ST_IDLE),
    .count_en (state == ST_DEFER && crs && bit_tick && cfg_defer_chk),
    .expired  (defer_exp)
  );

  assign jam_last = (state == ST_JAM) && bit_tick && (jam_cnt == JW'(JAM_BITS - 1));

  always_comb begin
    drop_now  = 1'b1;
    drop_code = OUT_RETRY_OFF;
    if (cfg_retry_dis)                      drop_code = OUT_RETRY_OFF;
    else if (late_hit && !cfg_late_retry)   drop_code = OUT_LATE;
    else if (coll_cnt == CNT_W'(MAX_ATTEMPTS)) drop_code = OUT_EXCESS;
    else                                    drop_now  = 1'b0;
  end

  hdx_backoff #(.SLOT_BITS(SLOT_BITS), .BACKOFF_CAP(BACKOFF_CAP), .ATT_W(CNT_W)) u_backoff (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (jam_last && !drop_now),
    .attempt (coll_cnt),
    .tick    (bit_tick),
    .busy    (bo_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      coll_cnt <= '0;
      late_hit <= 1'b0;
      bit_cnt  <= '0;
      jam_cnt  <= '0;
      status   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (tx_req) begin
          state    <= ST_DEFER;
          coll_cnt <= '0;
          late_hit <= 1'b0;
        end
        ST_DEFER: begin
          if (!crs) begin
            state   <= ST_XMIT;
            bit_cnt <= '0;
          end else if (defer_exp) begin
            status <= {coll_cnt, OUT_DEFER};
            state  <= ST_DONE;
          end
        end
        ST_XMIT: begin
          if (col) begin
            coll_cnt <= coll_cnt + 1'b1;
            late_hit <= (bit_cnt == BW'(LATE_BITS));
            jam_cnt  <= '0;
            state    <= ST_JAM;
          end else if (frame_end) begin
            status <= {coll_cnt, OUT_OK};
            state  <= ST_DONE;
          end else if (bit_tick && bit_cnt != BW'(LATE_BITS)) begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_JAM: begin
          if (jam_last) begin
            if (drop_now) begin
              status <= {coll_cnt, drop_code};
              state  <= ST_DONE;
            end else begin
              state <= ST_BACKOFF;
            end
          end else if (bit_tick) begin
            jam_cnt <= jam_cnt + 1'b1;
          end
        end
        ST_BACKOFF: if (!bo_busy) state <= ST_DEFER;
        ST_DONE:    state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign tx_en          = (state == ST_XMIT);
  assign jam            = (state == ST_JAM);
  assign backoff_active = (state == ST_BACKOFF);
  assign status_valid   = (state == ST_DONE);

  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> !$past(crs)); // R1
  AST_COL_JAMS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && col) |=> (jam && !tx_en)); // R3
  AST_BACKOFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_active |-> (!tx_en && !jam)); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> $countones(status[OUTCOME_W-1:0]) == 1); // R9
  AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |=> !status_valid); // R9
  AST_COLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    coll_cnt <= CNT_W'(MAX_ATTEMPTS)); // R6
endmodule

// File: tb/hdx_tx_arbiter_tb.sv
module hdx_tx_arbiter_tb;
  localparam int DLIM = 40;
  localparam int SLOT = 8;
  localparam int JAMB = 4;
  localparam int LATE = 16;
  localparam int MAXA = 16;
  localparam int CAP  = 4;
  localparam int FLEN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 0, crs = 0, col = 0, bit_tick = 1, frame_end = 0;
  logic cfg_defer_chk = 0, cfg_retry_dis = 0, cfg_late_retry = 0;
  logic tx_en, jam, backoff_active, status_valid;
  logic [9:0] status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  hdx_tx_arbiter #(.DEFER_LIMIT(DLIM), .SLOT_BITS(SLOT), .JAM_BITS(JAMB),
    .LATE_BITS(LATE), .MAX_ATTEMPTS(MAXA), .BACKOFF_CAP(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .crs(crs), .col(col),
    .bit_tick(bit_tick), .frame_end(frame_end), .cfg_defer_chk(cfg_defer_chk),
    .cfg_retry_dis(cfg_retry_dis), .cfg_late_retry(cfg_late_retry),
    .tx_en(tx_en), .jam(jam), .backoff_active(backoff_active),
    .status_valid(status_valid), .status(status));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expect_status(input int ncol, input int defer_cyc,
      input bit dchk, input bit rdis, input bit lok, input int offs[20]);
    if (dchk && defer_cyc >= DLIM + 2) return 32'b00010;          // R2
    for (int i = 0; i < ncol; i++) begin
      int c = i + 1;
      if (rdis) return (c << 5) | 5'b10000;                        // R4, R10
      if (offs[i] >= LATE && !lok) return (c << 5) | 5'b01000;     // R5
      if (c == MAXA) return (c << 5) | 5'b00100;                   // R6
    end
    return (ncol << 5) | 5'b00001;                                 // R8
  endfunction

  task automatic run_frame(input string tag, input int ncol, input int defer_cyc,
      input bit dchk, input bit rdis, input bit lok, input int offs[20]);
    int left = defer_cyc;
    int a = 0, k = 0, jl = 0, bl = 0, guard = 0;
    bit ptx = 0, pjam = 0, pbo = 0, crs_edge;
    int exp = expect_status(ncol, defer_cyc, dchk, rdis, lok, offs);
    @(negedge clk);
    cfg_defer_chk = dchk; cfg_retry_dis = rdis; cfg_late_retry = lok;
    crs = (left > 0);
    tx_req = 1'b1;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 20000) begin
        chk(0, "R9", {tag, " frame hung"}, guard, 0);
        break;
      end
      if (status_valid) begin
        chk(status == 10'(exp), "R9", {tag, " status"}, int'(status), exp);
        tx_req = 1'b0; col = 0; frame_end = 0; crs = 0;
        @(negedge clk);
        chk(!status_valid, "R9", {tag, " strobe width"}, int'(status_valid), 0);
        break;
      end
      crs_edge = crs;
      if (left > 0) left--;
      crs = (left > 0);
      col = 0; frame_end = 0;
      if (tx_en) begin
        if (!ptx) begin
          k = 0;
          chk(!crs_edge, "R1", {tag, " grant under carrier"}, int'(crs_edge), 0);
        end
        if (a < ncol && k == offs[a]) col = 1;
        else if (a >= ncol && k == FLEN - 1) frame_end = 1;
        k++;
      end else if (ptx) a++;
      if (jam) jl++;
      else if (pjam) begin
        chk(jl == JAMB, "R3", {tag, " jam length"}, jl, JAMB);
        jl = 0;
      end
      if (backoff_active) begin
        bl++;
        if (tx_en || jam) chk(0, "R7", {tag, " activity in backoff"}, 1, 0);
      end else if (pbo) begin
        int e = (a < CAP) ? a : CAP;
        int mx = ((1 << e) - 1) * SLOT + 1;
        chk(bl <= mx && ((bl - 1) % SLOT) == 0, "R7", {tag, " backoff length"}, bl, mx);
        bl = 0;
      end
      ptx = tx_en; pjam = jam; pbo = backoff_active;
    end
  endtask

  initial begin
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int offs[20];
    process::self().srandom(32'h5EED);
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(!tx_en && !jam && !backoff_active && !status_valid, "R11", "in reset",
        {tx_en, jam, backoff_active, status_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_en && !jam && !backoff_active && !status_valid, "R11", "after reset",
        {tx_en, jam, backoff_active, status_valid}, 0);

    for (int i = 0; i < 20; i++) offs[i] = 3;
    run_frame("R8 clean", 0, 0, 0, 0, 0, offs);
    run_frame("R1 short defer", 0, DLIM - 5, 1, 0, 0, offs);
    run_frame("R2 defer drop", 0, DLIM + 10, 1, 0, 0, offs);
    run_frame("R2 defer unchecked", 0, DLIM + 10, 0, 0, 0, offs);
    run_frame("R4 retry off", 1, 0, 0, 1, 0, offs);
    run_frame("R7 two retries", 2, 0, 0, 0, 0, offs);
    run_frame("R6 limit", 17, 0, 0, 0, 0, offs);
    run_frame("R6 below limit", 15, 0, 0, 0, 0, offs);
    offs[0] = LATE;
    run_frame("R5 late drop", 1, 0, 0, 0, 0, offs);
    run_frame("R5 late retried", 1, 0, 0, 0, 1, offs);
    run_frame("R10 retry over late", 1, 0, 0, 1, 0, offs);
    offs[0] = LATE - 1;
    run_frame("R5 last early bit", 1, 0, 0, 0, 0, offs);

    for (int n = 0; n < 30; n++) begin
      int nc = $urandom_range(0, 17);
      for (int i = 0; i < 20; i++)
        offs[i] = ($urandom_range(0, 5) == 0) ? $urandom_range(LATE, FLEN - 2)
                                              : $urandom_range(0, LATE - 1);
      run_frame("R9 random", nc, $urandom_range(0, 10), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)), offs);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule